// File: doc/BRIEF.md
# Address Sequence Store/Recall Trigger

This block sits beside a byte-wide SRAM that has a nonvolatile shadow copy. It watches each chip-enable-controlled access (a one-cycle strobe carrying a 13-bit address, an active-low write enable and an active-low output enable). It recognises the fixed six-read unlock series that requests a copy of the SRAM into the shadow (store) or a reload of the SRAM from the shadow (recall). There is no command register. The series is five fixed reads followed by a final read whose address selects the operation. Any write, and any read at an address other than the expected one, silently drops the series.

When a series completes, the block emits a one-cycle start pulse and holds a busy flag for a parameterised number of clock cycles. While busy, it ignores every access and asks for the data bus to be released. It also reports which internal step of the operation is running, so that the array and shadow logic can follow: erase then program for a store, clear then load for a recall. A low-supply flag blocks a store but not a recall.

Top module: `nv_seq_trigger`

## Requirements
- R1: Reads (write_n_i high) at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, each on consecutive accesses, raise store_start_o for exactly one cycle, in the cycle after the clock edge that samples the sixth access.
- R2: The same five reads followed by a read at 0x0F0E raise recall_start_o for exactly one cycle, with the same timing. No more than one start pulse is ever high at a time.
- R3: An access with write_n_i low resets the series. The remaining reads of the series then start nothing.
- R4: A read at an address other than the next expected one resets the series. If that address is 0x0000, it counts as the first step of a new series.
- R5: out_en_n_i has no effect on how the series advances.
- R6: dq_hiz_o is 0 only during a non-busy read access with out_en_n_i low that does not complete a series. It is 1 on the sixth read of a completed series, while busy, and when there is no access.
- R7: busy_o rises together with a start pulse. It stays high for exactly STORE_CYCLES cycles after a store start, and for exactly RECALL_CYCLES cycles after a recall start.
- R8: Accesses while busy_o is high neither advance the series nor start an operation. The series restarts from empty when busy ends.
- R9: If low_vcc_i is high on the sixth read of a store series, no store starts, busy_o stays low and the series is consumed. A recall series still starts a recall.
- R10: nv_phase_o encodes 0 = idle, 1 = erase, 2 = program, 3 = clear, 4 = load. A store shows erase for its first floor(STORE_CYCLES/2) busy cycles and program for the rest. A recall shows clear for its first floor(RECALL_CYCLES/2) busy cycles and load for the rest. nv_phase_o is idle when not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | One-cycle strobe per chip-enable-controlled access |
| addr_i | input | 13 | Access address |
| write_n_i | input | 1 | Active-low write enable of the access |
| out_en_n_i | input | 1 | Active-low output enable of the access |
| low_vcc_i | input | 1 | Supply below switch threshold |
| store_start_o | output | 1 | One-cycle store start pulse |
| recall_start_o | output | 1 | One-cycle recall start pulse |
| busy_o | output | 1 | Operation in progress; accesses are ignored |
| dq_hiz_o | output | 1 | Request to release the data bus |
| nv_phase_o | output | 3 | Internal step of the running operation |

## Verification
The embedded properties check on every cycle the following: the series counter stays within range, a write always empties it, the counter holds while busy, no start is raised while busy or under low supply, start pulses last one cycle and never coincide, and each operation steps only forward. Only the bench scenarios can show the full address-order matching, including restart on 0x0000 and selection by the final address. The same holds for the exact busy length, the position of the phase split, and the fact that an unlock series driven during busy leaves nothing behind afterwards.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  localparam int ADDR_W  = 13;
  localparam int SEQ_LEN = 6;

  localparam logic [ADDR_W-1:0] KEY_STORE  = 13'h0F0F;
  localparam logic [ADDR_W-1:0] KEY_RECALL = 13'h0F0E;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ERASE   = 3'd1,
    PH_PROGRAM = 3'd2,
    PH_CLEAR   = 3'd3,
    PH_LOAD    = 3'd4
  } nv_phase_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } nv_op_e;

  // fixed prefix of the unlock series, step 0..4
  function automatic logic [ADDR_W-1:0] seq_key(input logic [2:0] idx);
    case (idx)
      3'd0:    seq_key = 13'h0000;
      3'd1:    seq_key = 13'h1555;
      3'd2:    seq_key = 13'h0AAA;
      3'd3:    seq_key = 13'h1FFF;
      3'd4:    seq_key = 13'h10F0;
      default: seq_key = 13'h0000;
    endcase
  endfunction
endpackage

// File: rtl/nv_seq_tracker.sv
module nv_seq_tracker
  import nv_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_n_i,
  input  logic              low_vcc_i,
  input  logic              busy_i,
  input  logic              clear_i,
  output logic              store_fire_o,
  output logic              recall_fire_o,
  output logic              final_hit_o,
  output logic              store_start_o,
  output logic              recall_start_o
);
  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step_q, step_d;
  logic live, at_last, hit_store, hit_recall;

  assign live       = acc_valid_i & ~busy_i;
  assign at_last    = (step_q == LAST_STEP);
  assign hit_store  = at_last & (addr_i == KEY_STORE);
  assign hit_recall = at_last & (addr_i == KEY_RECALL);

  assign final_hit_o   = live & write_n_i & (hit_store | hit_recall);
  assign store_fire_o  = final_hit_o & hit_store & ~low_vcc_i;
  assign recall_fire_o = final_hit_o & hit_recall;

  always_comb begin
    step_d = step_q;
    if (clear_i) begin
      step_d = '0;
    end else if (live) begin
      if (!write_n_i || final_hit_o) begin
        step_d = '0;
      end else if (!at_last && addr_i == seq_key(3'(step_q))) begin
        step_d = step_q + STEP_W'(1);
      end else if (addr_i == '0) begin
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q         <= '0;
      store_start_o  <= 1'b0;
      recall_start_o <= 1'b0;
    end else begin
      step_q         <= step_d;
      store_start_o  <= store_fire_o;
      recall_start_o <= recall_fire_o;
    end
  end

  a_r1_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST_STEP);

  a_r3_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !write_n_i) |=> step_q == '0);

  a_r8_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clear_i) |=> step_q == $past(step_q));

  a_r9_store_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> $past(!low_vcc_i));

  a_r1_store_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |=> !store_start_o);

  a_r2_recall_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_start_o |=> !recall_start_o);

  a_r2_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_start_o && recall_start_o));
endmodule

// File: rtl/nv_busy_timer.sv
module nv_busy_timer
  import nv_seq_pkg::*;
#(
  parameter int STORE_CYCLES  = 1_000_000,
  parameter int RECALL_CYCLES = 2_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       store_fire_i,
  input  logic       recall_fire_i,
  output logic       busy_o,
  output logic       done_o,
  output nv_phase_e  phase_o
);
  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] STORE_LAST  = CNT_W'(STORE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECALL_LAST = CNT_W'(RECALL_CYCLES - 1);
  localparam logic [CNT_W-1:0] STORE_HALF  = CNT_W'(STORE_CYCLES / 2);
  localparam logic [CNT_W-1:0] RECALL_HALF = CNT_W'(RECALL_CYCLES / 2);

  nv_op_e           op_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (op_q != OP_NONE);
  assign done_o = (op_q == OP_STORE  && cnt_q == STORE_LAST) ||
                  (op_q == OP_RECALL && cnt_q == RECALL_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_NONE;
      cnt_q <= '0;
    end else if (store_fire_i || recall_fire_i) begin
      op_q  <= store_fire_i ? OP_STORE : OP_RECALL;
      cnt_q <= '0;
    end else if (done_o) begin
      op_q  <= OP_NONE;
      cnt_q <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    case (op_q)
      OP_STORE:  phase_o = (cnt_q < STORE_HALF)  ? PH_ERASE : PH_PROGRAM;
      OP_RECALL: phase_o = (cnt_q < RECALL_HALF) ? PH_CLEAR : PH_LOAD;
      default:   phase_o = PH_IDLE;
    endcase
  end

  a_r7_no_fire_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(store_fire_i || recall_fire_i));

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q <= ((op_q == OP_STORE) ? STORE_LAST : RECALL_LAST));

  a_r10_program_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_PROGRAM) |=> (phase_o == PH_PROGRAM || phase_o == PH_IDLE));

  a_r10_load_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_LOAD) |=> (phase_o == PH_LOAD || phase_o == PH_IDLE));
endmodule

// File: rtl/nv_seq_trigger.sv
module nv_seq_trigger
  import nv_seq_pkg::*;
#(
  parameter int STORE_CYCLES  = 1_000_000,
  parameter int RECALL_CYCLES = 2_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_valid_i,
  input  logic [12:0] addr_i,
  input  logic        write_n_i,
  input  logic        out_en_n_i,
  input  logic        low_vcc_i,
  output logic        store_start_o,
  output logic        recall_start_o,
  output logic        busy_o,
  output logic        dq_hiz_o,
  output logic [2:0]  nv_phase_o
);
  logic store_fire, recall_fire, final_hit, done;
  nv_phase_e phase;

  nv_seq_tracker u_tracker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .acc_valid_i   (acc_valid_i),
    .addr_i        (addr_i),
    .write_n_i     (write_n_i),
    .low_vcc_i     (low_vcc_i),
    .busy_i        (busy_o),
    .clear_i       (done),
    .store_fire_o  (store_fire),
    .recall_fire_o (recall_fire),
    .final_hit_o   (final_hit),
    .store_start_o (store_start_o),
    .recall_start_o(recall_start_o)
  );

  nv_busy_timer #(
    .STORE_CYCLES (STORE_CYCLES),
    .RECALL_CYCLES(RECALL_CYCLES)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .store_fire_i (store_fire),
    .recall_fire_i(recall_fire),
    .busy_o       (busy_o),
    .done_o       (done),
    .phase_o      (phase)
  );

  assign nv_phase_o = phase;
  // bus driven only for a plain read with output enable asserted
  assign dq_hiz_o = ~(acc_valid_i & write_n_i & ~out_en_n_i & ~busy_o & ~final_hit);

  a_r7_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (store_start_o || recall_start_o));

  a_r6_hiz_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> dq_hiz_o);
endmodule

// File: tb/tb_nv_seq_trigger.sv
`timescale 1ns/1ps
module tb_nv_seq_trigger;
  localparam int ST = 40;
  localparam int RC = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid = 1'b0;
  logic [12:0] addr = '0;
  logic        write_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        low_vcc = 1'b0;
  logic        store_start, recall_start, busy, dq_hiz;
  logic [2:0]  phase;

  always #5 clk = ~clk;

  nv_seq_trigger #(.STORE_CYCLES(ST), .RECALL_CYCLES(RC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(acc_valid), .addr_i(addr),
    .write_n_i(write_n), .out_en_n_i(oe_n), .low_vcc_i(low_vcc),
    .store_start_o(store_start), .recall_start_o(recall_start), .busy_o(busy),
    .dq_hiz_o(dq_hiz), .nv_phase_o(phase)
  );

  int checks = 0;
  int errors = 0;
  int step_m = 0;

  function automatic logic [12:0] pat(input int i);
    case (i)
      0: pat = 13'h0000;
      1: pat = 13'h1555;
      2: pat = 13'h0AAA;
      3: pat = 13'h1FFF;
      4: pat = 13'h10F0;
      default: pat = 13'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one access: drive at negedge, sample combinational hiz mid-cycle, outputs at next negedge
  task automatic access(input logic [12:0] a, input logic wn, input logic oen, input logic lv,
                        output int hz, output int st, output int rc);
    @(negedge clk);
    acc_valid = 1'b1; addr = a; write_n = wn; oe_n = oen; low_vcc = lv;
    #1 hz = dq_hiz;
    @(negedge clk);
    acc_valid = 1'b0; write_n = 1'b1; oe_n = 1'b1; low_vcc = 1'b0;
    st = store_start; rc = recall_start;
  endtask

  // R7 / R10: called at the negedge right after the start edge
  task automatic check_window(input int n, input int ph_a, input int ph_b, input string tag);
    int bad = 0;
    for (int j = 0; j < n; j++) begin
      if (busy !== 1'b1) bad++;
      if (dq_hiz !== 1'b1) bad++;
      if (int'(phase) != ((j < n / 2) ? ph_a : ph_b)) bad++;
      if (j > 0 && (store_start || recall_start)) bad++;
      if (j == 0) chk({tag, " R10 first phase"}, int'(phase), ph_a);
      if (j == n / 2) chk({tag, " R10 second phase"}, int'(phase), ph_b);
      @(negedge clk);
    end
    chk({tag, " R7 window cycles wrong"}, bad, 0);
    chk({tag, " R7 busy drops after window"}, int'(busy), 0);
    chk({tag, " R10 idle after window"}, int'(phase), 0);
  endtask

  task automatic run_access(input logic [12:0] a, input logic wn, input logic oen,
                            input logic lv, input string tag);
    int hz, st, rc, e_hz, e_st, e_rc;
    logic fin;
    fin  = (step_m == 5) && wn && (a == 13'h0F0F || a == 13'h0F0E);
    e_hz = (wn && !oen && !fin) ? 0 : 1;
    e_st = (fin && a == 13'h0F0F && !lv) ? 1 : 0;
    e_rc = (fin && a == 13'h0F0E) ? 1 : 0;
    if (!wn || fin) step_m = 0;
    else if (step_m < 5 && a == pat(step_m)) step_m++;
    else if (a == 13'h0000) step_m = 1;
    else step_m = 0;
    access(a, wn, oen, lv, hz, st, rc);
    chk({tag, " R6 hiz"}, hz, e_hz);
    chk({tag, " R1 store_start"}, st, e_st);
    chk({tag, " R2 recall_start"}, rc, e_rc);
    if (e_st == 1) check_window(ST, 1, 2, tag);
    else if (e_rc == 1) check_window(RC, 3, 4, tag);
    else chk({tag, " R9 no busy"}, int'(busy), 0);
  endtask

  task automatic prefix(input logic oen, input string tag);
    for (int i = 0; i < 5; i++) run_access(pat(i), 1'b1, oen, 1'b0, tag);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int hz, st, rc, guard;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("reset busy", int'(busy), 0);
    chk("reset store_start", int'(store_start), 0);
    chk("reset recall_start", int'(recall_start), 0);
    chk("reset R10 phase", int'(phase), 0);
    chk("reset R6 hiz idle", int'(dq_hiz), 1);

    // R1 store with output enable low, R6 hiz on sixth
    prefix(1'b0, "R1 store");
    run_access(13'h0F0F, 1'b1, 1'b0, 1'b0, "R1 store final");

    // R2 recall with output enable high (R5)
    prefix(1'b1, "R5 oe high");
    run_access(13'h0F0E, 1'b1, 1'b1, 1'b0, "R2 recall final");

    // R3 write inside series
    run_access(13'h0000, 1'b1, 1'b0, 1'b0, "R3");
    run_access(13'h1555, 1'b1, 1'b0, 1'b0, "R3");
    run_access(13'h0AAA, 1'b0, 1'b1, 1'b0, "R3 write");
    run_access(13'h1FFF, 1'b1, 1'b0, 1'b0, "R3");
    run_access(13'h10F0, 1'b1, 1'b0, 1'b0, "R3");
    run_access(13'h0F0F, 1'b1, 1'b0, 1'b0, "R3 no store");

    // R4 mismatch aborts
    run_access(13'h0000, 1'b1, 1'b0, 1'b0, "R4");
    run_access(13'h1555, 1'b1, 1'b0, 1'b0, "R4");
    run_access(13'h0123, 1'b1, 1'b0, 1'b0, "R4 stray");
    run_access(13'h0AAA, 1'b1, 1'b0, 1'b0, "R4");
    run_access(13'h1FFF, 1'b1, 1'b0, 1'b0, "R4");
    run_access(13'h10F0, 1'b1, 1'b0, 1'b0, "R4");
    run_access(13'h0F0E, 1'b1, 1'b0, 1'b0, "R4 no recall");
    // R4 restart on 0x0000 mid series and at the final step
    run_access(13'h0000, 1'b1, 1'b0, 1'b0, "R4 restart");
    run_access(13'h1555, 1'b1, 1'b0, 1'b0, "R4 restart");
    prefix(1'b0, "R4 restart");
    run_access(13'h0000, 1'b1, 1'b0, 1'b0, "R4 restart at final");
    for (int i = 1; i < 5; i++) run_access(pat(i), 1'b1, 1'b0, 1'b0, "R4 restart");
    run_access(13'h0F0F, 1'b1, 1'b0, 1'b0, "R4 restart store");

    // R9 low supply
    prefix(1'b0, "R9");
    run_access(13'h0F0F, 1'b1, 1'b0, 1'b1, "R9 store blocked");
    run_access(13'h0F0F, 1'b1, 1'b0, 1'b0, "R9 series consumed");
    prefix(1'b0, "R9");
    run_access(13'h0F0E, 1'b1, 1'b0, 1'b1, "R9 recall allowed");

    // R8 accesses during busy are ignored
    prefix(1'b0, "R8");
    access(13'h0F0F, 1'b1, 1'b0, 1'b0, hz, st, rc);
    chk("R8 store start", st, 1);
    for (int i = 0; i < 5; i++) begin
      access(pat(i), 1'b1, 1'b0, 1'b0, hz, st, rc);
      chk("R8 R6 hiz while busy", hz, 1);
      chk("R8 no start while busy", st | rc, 0);
    end
    guard = 0;
    while (busy && guard < 100) begin @(negedge clk); guard++; end
    chk("R8 busy ended", int'(busy), 0);
    step_m = 0;
    run_access(13'h0F0E, 1'b1, 1'b0, 1'b0, "R8 series cleared");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [12:0] a;
      logic wn, oen, lv;
      if (($urandom % 10) < 7)
        a = (step_m < 5) ? pat(step_m) : (($urandom % 2) ? 13'h0F0F : 13'h0F0E);
      else if (($urandom % 4) == 0)
        a = 13'h0000;
      else
        a = 13'($urandom);
      wn  = (($urandom % 10) != 0);
      oen = 1'($urandom);
      lv  = (($urandom % 6) == 0);
      run_access(a, wn, oen, lv, "rand R1 R2 R3 R4");
    end

    finish_run();
  end
endmodule